// File: doc/BRIEF.md
# Packed Single-Precision Compare Unit

This block compares two packed vectors, each holding eight IEEE-754 single-precision lanes, under a 5-bit predicate code. Each lane produces a 32-bit mask that is either all ones (the predicate holds) or all zeros. An 8-bit summary holds one bit per lane. A sticky invalid-operation flag records NaN operands that the predicate treats as exceptional. The results are registered once, so they appear one clock after the request.

The predicate code selects the relation, the result given for unordered operands (a NaN in either lane), and whether a quiet NaN counts as an invalid operation. A legacy-mode select limits the block to the eight basic predicates. In legacy mode a higher code is rejected: the block flags it as illegal and produces an empty mask.

Top module: `fp_cmp_unit`

## Requirements
- R1: `resValid` is high exactly one cycle after `reqValid`. `laneMask`, `maskSummary` and `illegalPred` change only on the edge that registers an accepted request, and hold their values between requests.
- R2: For each lane i, bits [32i+31:32i] of `laneMask` are all ones when the predicate holds for `opA` lane i against `opB` lane i, and all zeros otherwise. Lane i occupies bits [32i+31:32i] of each operand. A lane is unordered when either operand is NaN.
- R3: The meaning of codes 0 to 15 is set by the low four bits of the code, in this order. Ordered predicates give false on an unordered lane; unordered predicates give true.
  - 0 equal, ordered, quiet
  - 1 less, ordered, signaling
  - 2 less-or-equal, ordered, signaling
  - 3 unordered test, quiet
  - 4 not-equal, unordered, quiet
  - 5 not-less, unordered, signaling
  - 6 not-less-or-equal, unordered, signaling
  - 7 ordered test, quiet
  - 8 equal, unordered, quiet
  - 9 not-greater-or-equal, unordered, signaling
  - 10 not-greater, unordered, signaling
  - 11 always false, quiet
  - 12 not-equal, ordered, quiet
  - 13 greater-or-equal, ordered, signaling
  - 14 greater, ordered, signaling
  - 15 always true, quiet
- R4: Codes 16 to 31 give the same relation and the same unordered result as the code 16 lower. Their signaling/quiet sense is inverted.
- R5: Bit i of `maskSummary` equals bit 32i+31 of `laneMask`.
- R6: An accepted, legal compare raises invalid when any lane holds a signaling NaN, whatever the predicate. It also raises invalid when any lane holds a quiet NaN and the predicate is signaling. A quiet NaN under a quiet predicate raises nothing.
- R7: `invalidFlag` is sticky, the OR over all lanes and all accepted compares. It returns to 0 only on the edge after `clrInvalid` is high. If a new invalid event arrives in the same cycle as a clear, the flag stays set.
- R8: With `legacyMode` high, a code of 8 or above sets `illegalPred` and forces `laneMask` and `maskSummary` to zero, and it raises no invalid. Codes 0 to 7 behave as in R3. `illegalPred` drops on the next accepted legal request.
- R9: +0 and -0 compare equal. A NaN has an all-ones exponent (bits 30:23) and a nonzero fraction. A NaN is quiet when fraction bit 22 is 1 and signaling otherwise. Infinities are ordered.
- R10: The always-false codes (11, 27) give an all-zero mask and the always-true codes (15, 31) give an all-ones mask, even for NaN lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| opA | input | 256 | First packed operand, lane i in bits [32i+31:32i] |
| opB | input | 256 | Second packed operand |
| predCode | input | 5 | Predicate code |
| legacyMode | input | 1 | Restrict to codes 0 to 7 |
| clrInvalid | input | 1 | Clear the sticky invalid flag |
| resValid | output | 1 | Result strobe |
| laneMask | output | 256 | Per-lane all-ones/all-zeros result |
| maskSummary | output | 8 | One bit per lane, lane 0 in bit 0 |
| invalidFlag | output | 1 | Sticky invalid-operation flag |
| illegalPred | output | 1 | Last request used a code not allowed in legacy mode |

## Verification
Every result of a request is due exactly one edge after it is presented: the strobe, the mask, the summary, the illegal indication and the invalid update. A clear also takes effect on that one edge. The bench drives on the falling edge and updates a behavioural model with the same one-edge delay. On the next falling edge it compares every output against that model, so all five results are checked on every cycle, idle cycles included. Idle cycles are placed between requests to confirm that the registered results hold.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  // relSel bit order: {unordered, less, equal, greater}
  typedef struct packed {
    logic       load;
    logic       illegal;
    logic       sigQnan;
    logic [3:0] relSel;
  } cmpCtl_t;
endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  logic [3:0]            relSel,
  input  logic                  sigQnan,
  output logic                  hit,
  output logic                  inv
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic nanA, nanB, qA, qB, sA, sB, unord, bothZero, isEq, isLt, isGt;

  always_comb begin
    nanA = (&a[W-2 -: EXP_W]) && (|a[FRAC_W-1:0]);
    nanB = (&b[W-2 -: EXP_W]) && (|b[FRAC_W-1:0]);
    qA = nanA && a[FRAC_W-1];
    qB = nanB && b[FRAC_W-1];
    sA = nanA && !a[FRAC_W-1];
    sB = nanB && !b[FRAC_W-1];
    unord = nanA || nanB;
    bothZero = !(|a[W-2:0]) && !(|b[W-2:0]);
    isEq = bothZero || (a == b);
    if (a[W-1] != b[W-1])
      isLt = a[W-1] && !bothZero;
    else if (!a[W-1])
      isLt = a[W-2:0] < b[W-2:0];
    else
      isLt = a[W-2:0] > b[W-2:0];
    isGt = !isLt && !isEq;
    if (unord)
      hit = relSel[3];
    else
      hit = (isLt && relSel[2]) || (isEq && relSel[1]) || (isGt && relSel[0]);
    inv = sA || sB || (sigQnan && (qA || qB));
  end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [4:0] predCode,
  input  logic       legacyMode,
  output cmpCtl_t    ctl,
  output logic       resValid,
  output logic       illegalPred
);
  logic       baseSig;
  logic [3:0] baseRel;

  always_comb begin
    unique case (predCode[3:0])
      4'd0:  begin baseRel = 4'b0010; baseSig = 1'b0; end
      4'd1:  begin baseRel = 4'b0100; baseSig = 1'b1; end
      4'd2:  begin baseRel = 4'b0110; baseSig = 1'b1; end
      4'd3:  begin baseRel = 4'b1000; baseSig = 1'b0; end
      4'd4:  begin baseRel = 4'b1101; baseSig = 1'b0; end
      4'd5:  begin baseRel = 4'b1011; baseSig = 1'b1; end
      4'd6:  begin baseRel = 4'b1001; baseSig = 1'b1; end
      4'd7:  begin baseRel = 4'b0111; baseSig = 1'b0; end
      4'd8:  begin baseRel = 4'b1010; baseSig = 1'b0; end
      4'd9:  begin baseRel = 4'b1100; baseSig = 1'b1; end
      4'd10: begin baseRel = 4'b1110; baseSig = 1'b1; end
      4'd11: begin baseRel = 4'b0000; baseSig = 1'b0; end
      4'd12: begin baseRel = 4'b0101; baseSig = 1'b0; end
      4'd13: begin baseRel = 4'b0011; baseSig = 1'b1; end
      4'd14: begin baseRel = 4'b0001; baseSig = 1'b1; end
      default: begin baseRel = 4'b1111; baseSig = 1'b0; end
    endcase
    ctl.load    = reqValid;
    ctl.illegal = legacyMode && (predCode[4] || predCode[3]);
    ctl.sigQnan = baseSig ^ predCode[4];
    ctl.relSel  = baseRel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      illegalPred <= 1'b0;
    end else begin
      resValid <= reqValid;
      if (reqValid) illegalPred <= ctl.illegal;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(illegalPred));
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] opA,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] opB,
  input  cmpCtl_t                      ctl,
  input  logic                         clrInvalid,
  output logic [LANES*(1+EXP_W+FRAC_W)-1:0] laneMask,
  output logic [LANES-1:0]             maskSummary,
  output logic                         invalidFlag
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int VW = LANES * W;

  logic [LANES-1:0] hits, invs;
  logic [VW-1:0]    maskNext;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    fcmp_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uLane (
      .a      (opA[i*W +: W]),
      .b      (opB[i*W +: W]),
      .relSel (ctl.relSel),
      .sigQnan(ctl.sigQnan),
      .hit    (hits[i]),
      .inv    (invs[i])
    );
    assign maskNext[i*W +: W] = {W{hits[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneMask    <= '0;
      maskSummary <= '0;
      invalidFlag <= 1'b0;
    end else begin
      if (ctl.load) begin
        laneMask    <= ctl.illegal ? '0 : maskNext;
        maskSummary <= ctl.illegal ? '0 : hits;
      end
      invalidFlag <= (invalidFlag && !clrInvalid) ||
                     (ctl.load && !ctl.illegal && (|invs));
    end
  end

  assert_mask_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(laneMask) && $stable(maskSummary));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag && !clrInvalid |=> invalidFlag);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrInvalid && !ctl.load |=> !invalidFlag);
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fcmp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int VW = LANES * (1 + EXP_W + FRAC_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VW-1:0]    opA,
  input  logic [VW-1:0]    opB,
  input  logic [4:0]       predCode,
  input  logic             legacyMode,
  input  logic             clrInvalid,
  output logic             resValid,
  output logic [VW-1:0]    laneMask,
  output logic [LANES-1:0] maskSummary,
  output logic             invalidFlag,
  output logic             illegalPred
);
  cmpCtl_t ctl;

  fcmp_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .predCode   (predCode),
    .legacyMode (legacyMode),
    .ctl        (ctl),
    .resValid   (resValid),
    .illegalPred(illegalPred)
  );

  fcmp_datapath #(.LANES(LANES), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .opA        (opA),
    .opB        (opB),
    .ctl        (ctl),
    .clrInvalid (clrInvalid),
    .laneMask   (laneMask),
    .maskSummary(maskSummary),
    .invalidFlag(invalidFlag)
  );

  assert_illegal_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && legacyMode && (predCode[4] || predCode[3]) |=> illegalPred && (laneMask == '0));
  assert_false_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !legacyMode && predCode[3:0] == 4'd11 |=> laneMask == '0);
  assert_true_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !legacyMode && predCode[3:0] == 4'd15 |=> &laneMask);
endmodule

// File: tb/sim_fp_cmp_unit.sv
`timescale 1ns/1ps
module sim_fp_cmp_unit;
  logic clk = 0, rstN = 0, reqValid = 0, legacyMode = 0, clrInvalid = 0;
  logic [255:0] opA = '0, opB = '0;
  logic [4:0] predCode = '0;
  logic resValid, invalidFlag, illegalPred;
  logic [255:0] laneMask;
  logic [7:0] maskSummary;

  int total = 0, bad = 0;
  logic [255:0] expMask = '0;
  logic [7:0]   expSum = '0;
  logic         expValid = 0, expInv = 0, expIll = 0;
  string        expTag = "R1 reset";

  logic [31:0] pool [11];

  always #4 clk = ~clk;

  fp_cmp_unit u0 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .opA(opA), .opB(opB),
    .predCode(predCode), .legacyMode(legacyMode), .clrInvalid(clrInvalid),
    .resValid(resValid), .laneMask(laneMask), .maskSummary(maskSummary),
    .invalidFlag(invalidFlag), .illegalPred(illegalPred));

  function automatic logic isNan(logic [31:0] v);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  function automatic logic [31:0] orderKey(logic [31:0] v);
    if (v[30:0] == 0) return 32'h8000_0000;
    if (v[31]) return ~v;
    return v | 32'h8000_0000;
  endfunction

  function automatic logic refHit(logic [31:0] a, logic [31:0] b, logic [4:0] c);
    logic un, lt, eq, gt;
    un = isNan(a) || isNan(b);
    lt = orderKey(a) < orderKey(b);
    eq = orderKey(a) == orderKey(b);
    gt = orderKey(a) > orderKey(b);
    case (c[3:0])
      0: return !un && eq;
      1: return !un && lt;
      2: return !un && (lt || eq);
      3: return un;
      4: return un || !eq;
      5: return un || !lt;
      6: return un || gt;
      7: return !un;
      8: return un || eq;
      9: return un || lt;
      10: return un || lt || eq;
      11: return 1'b0;
      12: return !un && !eq;
      13: return !un && (gt || eq);
      14: return !un && gt;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic refInv(logic [31:0] a, logic [31:0] b, logic [4:0] c);
    logic sig, sn, qn;
    sig = (c[3:0] inside {4'd1, 4'd2, 4'd5, 4'd6, 4'd9, 4'd10, 4'd13, 4'd14}) ^ c[4];
    sn = (isNan(a) && !a[22]) || (isNan(b) && !b[22]);
    qn = (isNan(a) && a[22]) || (isNan(b) && b[22]);
    return sn || (sig && qn);
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R1 valid", {255'd0, resValid}, {255'd0, expValid});
    check(expTag, laneMask, expMask);
    check("R5 summary", {248'd0, maskSummary}, {248'd0, expSum});
    check({expTag, " invalid R6 R7"}, {255'd0, invalidFlag}, {255'd0, expInv});
    check({expTag, " illegal R8"}, {255'd0, illegalPred}, {255'd0, expIll});
  endtask

  task automatic step(logic v, logic [255:0] a, logic [255:0] b, logic [4:0] c,
                      logic leg, logic clr, string tag);
    logic anyInv;
    logic illeg;
    @(negedge clk);
    compareAll();
    reqValid = v; opA = a; opB = b; predCode = c; legacyMode = leg; clrInvalid = clr;
    expTag = tag;
    expValid = v;
    anyInv = 0;
    illeg = leg && (c >= 8);
    if (v) begin
      expIll = illeg;
      for (int i = 0; i < 8; i++) begin
        logic h;
        h = !illeg && refHit(a[i*32 +: 32], b[i*32 +: 32], c);
        expMask[i*32 +: 32] = h ? 32'hffff_ffff : 32'h0;
        expSum[i] = h;
        if (!illeg && refInv(a[i*32 +: 32], b[i*32 +: 32], c)) anyInv = 1;
      end
    end
    expInv = (clr ? 1'b0 : expInv) | anyInv;
  endtask

  function automatic logic [255:0] mk(int k, int sel);
    logic [255:0] r;
    for (int i = 0; i < 8; i++)
      r[i*32 +: 32] = sel == 0 ? pool[(i*3 + k) % 11] : pool[(i*5 + 2*k + 1) % 11];
    return r;
  endfunction

  function automatic logic [255:0] fill(logic [31:0] v);
    return {8{v}};
  endfunction

  initial begin
    pool[0] = 32'h3f80_0000; pool[1] = 32'hbf80_0000; pool[2] = 32'h0000_0000;
    pool[3] = 32'h8000_0000; pool[4] = 32'h4000_0000; pool[5] = 32'h7fc0_0000;
    pool[6] = 32'h7f80_0001; pool[7] = 32'h7f80_0000; pool[8] = 32'hff80_0000;
    pool[9] = 32'hc000_0000; pool[10] = 32'h0000_0001;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state and idle hold
    step(0, '0, '0, 0, 0, 0, "R1 reset");
    step(0, '0, '0, 0, 0, 0, "R1 idle");
    // R2 R3 R4: every code over several lane patterns, idle in between
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 4; k++)
        step(1, mk(k, 0), mk(k, 1), 5'(c), 0, 0, c < 16 ? "R3 R2" : "R4 R2");
      step(0, mk(9, 0), mk(9, 1), 5'(c), 0, 0, "R1 hold");
    end
    // R6: quiet NaN under quiet code raises nothing
    step(0, '0, '0, 0, 0, 1, "R7 clear");
    step(1, fill(32'h7fc0_0000), fill(32'h3f80_0000), 5'd0, 0, 0, "R6 qnan quiet");
    step(1, fill(32'h7fc0_0000), fill(32'h3f80_0000), 5'd16, 0, 0, "R6 R4 qnan signaling");
    step(0, '0, '0, 0, 0, 1, "R7 clear");
    step(1, fill(32'h3f80_0000), fill(32'h7fc0_0000), 5'd1, 0, 0, "R6 qnan lt");
    step(0, '0, '0, 0, 0, 0, "R7 sticky");
    step(0, '0, '0, 0, 0, 1, "R7 clear");
    step(1, fill(32'h7f80_0001), fill(32'h0), 5'd3, 0, 0, "R6 snan quiet code");
    // R7: set wins over clear in the same cycle
    step(1, fill(32'h7f80_0001), fill(32'h0), 5'd0, 0, 1, "R7 set with clear");
    step(0, '0, '0, 0, 0, 1, "R7 clear");
    // R8: legacy mode over all codes, illegal ones raise no invalid
    for (int c = 0; c < 32; c++)
      step(1, mk(c % 4, 0), fill(32'h7f80_0001), 5'(c), 1, c == 8, "R8 legacy");
    step(1, fill(32'h4000_0000), fill(32'h4000_0000), 5'd0, 1, 0, "R8 legal after illegal");
    // R9: signed zeros, infinities, NaN encodings
    step(1, fill(32'h0000_0000), fill(32'h8000_0000), 5'd0, 0, 0, "R9 zero eq");
    step(1, fill(32'h8000_0000), fill(32'h0000_0000), 5'd1, 0, 0, "R9 zero lt");
    step(1, fill(32'h7f80_0000), fill(32'h7f80_0000), 5'd7, 0, 0, "R9 inf ordered");
    step(1, fill(32'h7f80_0000), fill(32'h7f7f_ffff), 5'd14, 0, 0, "R9 inf gt");
    step(1, fill(32'hffc0_0000), fill(32'h0), 5'd3, 0, 1, "R9 neg qnan");
    // R10: constant codes with NaN lanes
    step(1, mk(1, 0), fill(32'h7fc0_0000), 5'd11, 0, 0, "R10 false");
    step(1, mk(1, 0), fill(32'h7fc0_0000), 5'd15, 0, 0, "R10 true");
    step(1, mk(2, 0), fill(32'h7f80_0001), 5'd27, 0, 0, "R10 false alt");
    step(1, mk(2, 0), mk(3, 1), 5'd31, 0, 0, "R10 true alt");
    step(0, '0, '0, 0, 0, 0, "R1 tail");
    step(0, '0, '0, 0, 0, 0, "R1 tail");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule